// File: doc/BRIEF.md
# Transmit Interpolation and Shaping Chain

This block is the digital part of a transmit path. It takes signed 16-bit samples from a signal processor and delivers rounded, saturated 14-bit samples to a DAC at twice the internal stream rate. A static pin picks one of two input rates. At the base rate, every sample enters the internal stream twice, two clock cycles apart. At the double rate, every sample enters once. The internal stream first passes through a first-order DC-blocking high-pass, which can be bypassed. It then goes through a 7-tap half-band interpolator that doubles the rate. The interpolator is built only from shifts and adds. The droop caused by repeating samples is left for the processor to correct.

The whole block runs from one clock at the output rate. An input strobe marks each accepted sample. In double-rate mode the strobes must be at least 2 cycles apart, and in base-rate mode at least 4 cycles apart. Each stream sample produces two outputs on consecutive cycles: the even (interpolated) phase first, then the odd (centre-tap) phase.

Top module: `txi_chain`

## Requirements
- R1: While reset is asserted and right after it is released, `out_vld` is 0 and `out_dat` is 0.
- R2: With `rate_fast`=1, each input strobe puts exactly one sample into the stream, so it yields exactly two output samples.
- R3: With `rate_fast`=0, each input sample enters the stream twice (copy insertion), the second time 2 cycles after the first, so it yields four output samples.
- R4: With `hp_bypass`=0, each stream sample x is replaced by y = yp − (yp >>> 6) + x − xp. Here yp and xp are the previous y and x, both 0 after reset, and >>> is an arithmetic (floor) shift. With a constant input, the output settles to within 16 LSB of zero.
- R5: With `hp_bypass`=1, the stream sample reaches the interpolator unchanged.
- R6: The even-phase output for the newest stream value v0 and older values v1, v2, v3 is round((−v0 + 9·v1 + 9·v2 − v3)/64). Rounding adds 32, then shifts right arithmetically by 6.
- R7: The odd-phase output is round(16·v1/64), using the same rounding as R6.
- R8: Outputs are saturated to the range −8192 … 8191.
- R9: The even-phase output is valid 4 cycles after the strobe that delivered its stream sample. The odd phase follows on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at the output sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_fast | input | 1 | 1: input at twice the base rate; 0: base rate with copy insertion |
| hp_bypass | input | 1 | 1: skip the DC-blocking high-pass |
| in_vld | input | 1 | Input sample strobe |
| in_dat | input | 16 | Signed input sample |
| out_vld | output | 1 | Output sample valid |
| out_dat | output | 14 | Signed saturated output sample |

## Verification
Full-scale random samples with random gaps are run in all four mode and bypass combinations. They expose errors in the tap arithmetic, the rounding and the order of the two phases, and copy-insertion errors show up as a missing or misplaced repeated sample. A single impulse fixes the cycle at which each phase appears. A long constant input separates a working high-pass, which decays toward zero, from a bypassed or broken one. Two four-sample patterns of alternating extremes drive the even-phase sum past both output limits, which shows that saturation works in each direction.

// File: rtl/txi_pkg.sv
package txi_pkg;
  // Output phase sequencer of the interpolator
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_EVEN = 2'd1,
    PH_ODD  = 2'd2
  } txi_phase_e;
endpackage

// File: rtl/txi_rate_eq.sv
module txi_rate_eq #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rate_fast,
  input  logic                in_vld,
  input  logic signed [W-1:0] in_dat,
  output logic                st_vld,
  output logic signed [W-1:0] st_dat
);
  localparam int CW = 2;
  localparam logic [CW-1:0] COPY_GAP = CW'(2);

  logic [CW-1:0]       cnt_q, cnt_d;
  logic                vld_d;
  logic signed [W-1:0] dat_d;

  always_comb begin
    cnt_d = cnt_q;
    if (in_vld && !rate_fast) cnt_d = COPY_GAP;
    else if (cnt_q != '0)     cnt_d = cnt_q - CW'(1);
    // repeated copy issued when the gap counter expires
    vld_d = in_vld || (cnt_q == CW'(1));
    dat_d = in_vld ? in_dat : st_dat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      st_vld <= 1'b0;
      st_dat <= '0;
    end else begin
      cnt_q  <= cnt_d;
      st_vld <= vld_d;
      st_dat <= dat_d;
    end
  end
endmodule

// File: rtl/txi_dc_block.sv
module txi_dc_block #(
  parameter int W  = 16,
  parameter int HW = 20,
  parameter int K  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bypass,
  input  logic                 st_vld,
  input  logic signed [W-1:0]  st_dat,
  output logic                 hp_vld,
  output logic signed [HW-1:0] hp_dat
);
  logic signed [HW-1:0] x_ext, xp_ext, y_d, out_d;
  logic signed [W-1:0]  xp_q;
  logic signed [HW-1:0] yp_q;

  always_comb begin
    x_ext  = HW'(st_dat);
    xp_ext = HW'(xp_q);
    // pole at 1 - 2^-K realised as a shift-subtract
    y_d    = yp_q - (yp_q >>> K) + (x_ext - xp_ext);
    out_d  = bypass ? x_ext : y_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xp_q   <= '0;
      yp_q   <= '0;
      hp_vld <= 1'b0;
      hp_dat <= '0;
    end else begin
      hp_vld <= st_vld;
      if (st_vld) begin
        xp_q   <= st_dat;
        yp_q   <= y_d;
        hp_dat <= out_d;
      end
    end
  end
endmodule

// File: rtl/txi_halfband_interp.sv
module txi_halfband_interp
  import txi_pkg::*;
#(
  parameter int HW = 20,
  parameter int OW = 14,
  parameter int RS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hp_vld,
  input  logic signed [HW-1:0] hp_dat,
  output logic                 out_vld,
  output logic signed [OW-1:0] out_dat
);
  localparam int NT = 4;
  localparam int SW = HW + 6;
  localparam logic signed [SW-1:0] HALF = SW'(2 ** (RS - 1));
  localparam logic signed [SW-1:0] OMAX = SW'((2 ** (OW - 1)) - 1);
  localparam logic signed [SW-1:0] OMIN = ~OMAX;

  logic signed [HW-1:0] tap_q [NT];
  txi_phase_e           ph_q, ph_d;
  logic signed [SW-1:0] pair_in, pair_out, even_s, odd_s, sel_s, rnd_s;
  logic signed [OW-1:0] sat_d;

  // delay line of the stream-rate samples
  for (genvar gi = 0; gi < NT; gi++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tap_q[gi] <= '0;
      else if (hp_vld) tap_q[gi] <= (gi == 0) ? hp_dat : tap_q[(gi == 0) ? 0 : gi - 1];
    end
  end

  always_comb begin
    pair_in  = SW'(tap_q[1]) + SW'(tap_q[2]);
    pair_out = SW'(tap_q[0]) + SW'(tap_q[3]);
    even_s   = (pair_in <<< 3) + pair_in - pair_out;   // 9*(v1+v2) - (v0+v3)
    odd_s    = SW'(tap_q[1]) <<< 4;                    // centre tap 16*v1
    sel_s    = (ph_q == PH_EVEN) ? even_s : odd_s;
    rnd_s    = (sel_s + HALF) >>> RS;
    if (rnd_s > OMAX)      sat_d = OMAX[OW-1:0];
    else if (rnd_s < OMIN) sat_d = OMIN[OW-1:0];
    else                   sat_d = rnd_s[OW-1:0];
    if (hp_vld)                ph_d = PH_EVEN;
    else if (ph_q == PH_EVEN)  ph_d = PH_ODD;
    else                       ph_d = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      out_vld <= 1'b0;
      out_dat <= '0;
    end else begin
      ph_q    <= ph_d;
      out_vld <= (ph_q != PH_IDLE);
      if (ph_q != PH_IDLE) out_dat <= sat_d;
    end
  end
endmodule

// File: rtl/txi_chain.sv
module txi_chain #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 14,
  parameter int HP_W  = 20,
  parameter int HP_K  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rate_fast,
  input  logic                    hp_bypass,
  input  logic                    in_vld,
  input  logic signed [IN_W-1:0]  in_dat,
  output logic                    out_vld,
  output logic signed [OUT_W-1:0] out_dat
);
  localparam int RND_SH = 4 + IN_W - OUT_W;

  logic                   st_vld, hp_vld;
  logic signed [IN_W-1:0] st_dat;
  logic signed [HP_W-1:0] hp_dat;

  txi_rate_eq #(.W(IN_W)) rate_eq_i (
    .clk(clk), .rst_n(rst_n), .rate_fast(rate_fast),
    .in_vld(in_vld), .in_dat(in_dat), .st_vld(st_vld), .st_dat(st_dat)
  );

  txi_dc_block #(.W(IN_W), .HW(HP_W), .K(HP_K)) dc_block_i (
    .clk(clk), .rst_n(rst_n), .bypass(hp_bypass),
    .st_vld(st_vld), .st_dat(st_dat), .hp_vld(hp_vld), .hp_dat(hp_dat)
  );

  txi_halfband_interp #(.HW(HP_W), .OW(OUT_W), .RS(RND_SH)) interp_i (
    .clk(clk), .rst_n(rst_n), .hp_vld(hp_vld), .hp_dat(hp_dat),
    .out_vld(out_vld), .out_dat(out_dat)
  );
endmodule

// File: rtl/txi_chain_chk.sv
module txi_chain_chk #(
  parameter int IN_W = 16,
  parameter int HP_W = 20
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rate_fast,
  input logic                   hp_bypass,
  input logic                   in_vld,
  input logic                   out_vld,
  input logic                   st_vld,
  input logic signed [IN_W-1:0] st_dat,
  input logic                   hp_vld,
  input logic signed [HP_W-1:0] hp_dat
);
  // R9
  even_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |-> ##4 out_vld);

  // R9
  odd_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_vld) |=> out_vld);

  // R2
  stream_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> st_vld);

  // R3
  copy_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !rate_fast) |-> ##6 out_vld);

  // R5
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_vld && hp_bypass) |=> (hp_vld && hp_dat == HP_W'($past(st_dat))));
endmodule

bind txi_chain txi_chain_chk #(.IN_W(IN_W), .HP_W(HP_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rate_fast(rate_fast), .hp_bypass(hp_bypass),
  .in_vld(in_vld), .out_vld(out_vld), .st_vld(st_vld), .st_dat(st_dat),
  .hp_vld(hp_vld), .hp_dat(hp_dat)
);

// File: tb/txi_chain_tb_top.sv
`timescale 1ns/1ps
module txi_chain_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic               rst_n, rate_fast, hp_bypass, in_vld;
  logic signed [15:0] in_dat;
  logic               out_vld;
  logic signed [13:0] out_dat;

  txi_chain dut_i (
    .clk(clk), .rst_n(rst_n), .rate_fast(rate_fast), .hp_bypass(hp_bypass),
    .in_vld(in_vld), .in_dat(in_dat), .out_vld(out_vld), .out_dat(out_dat)
  );

  int    n_chk = 0, n_fail = 0;
  int    exp_q[$];
  string cur_req = "R2";
  bit    fast_m, byp_m;
  int    m_xp, m_yp;
  int    m_t[4];
  int    max_seen, min_seen, last_seen;
  bit    done = 0;

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd_sat(int v);
    int r;
    r = (v + 32) >>> 6;
    if (r > 8191) r = 8191;
    if (r < -8192) r = -8192;
    return r;
  endfunction

  function automatic void model_push(int x);
    int y, s;
    y = m_yp - (m_yp >>> 6) + x - m_xp;
    m_xp = x;
    m_yp = y;
    s = byp_m ? x : y;
    m_t[3] = m_t[2]; m_t[2] = m_t[1]; m_t[1] = m_t[0]; m_t[0] = s;
    exp_q.push_back(rnd_sat(-m_t[0] + 9 * m_t[1] + 9 * m_t[2] - m_t[3]));
    exp_q.push_back(rnd_sat(16 * m_t[1]));
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      if (exp_q.size() == 0) check(1'b0, cur_req, int'(out_dat), -99999);
      else begin
        int e;
        e = exp_q.pop_front();
        check(int'(out_dat) == e, cur_req, int'(out_dat), e);
      end
      last_seen = int'(out_dat);
      if (int'(out_dat) > max_seen) max_seen = int'(out_dat);
      if (int'(out_dat) < min_seen) min_seen = int'(out_dat);
    end
  end

  task automatic do_reset(bit fast, bit byp);
    @(negedge clk);
    rst_n = 1'b0; in_vld = 1'b0; in_dat = '0;
    rate_fast = fast; hp_bypass = byp;
    fast_m = fast; byp_m = byp;
    m_xp = 0; m_yp = 0;
    for (int i = 0; i < 4; i++) m_t[i] = 0;
    exp_q.delete();
    max_seen = -100000; min_seen = 100000; last_seen = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(int x, int extra);
    @(negedge clk);
    in_vld = 1'b1;
    in_dat = 16'(x);
    model_push(x);
    if (!fast_m) model_push(x);
    @(negedge clk);
    in_vld = 1'b0;
    repeat ((fast_m ? 0 : 2) + extra) @(negedge clk);
  endtask

  task automatic drain;
    repeat (14) @(negedge clk);
    check(exp_q.size() == 0, "R2 R3 output count", exp_q.size(), 0);
  endtask

  task automatic random_run(bit fast, bit byp, int n, string req);
    do_reset(fast, byp);
    cur_req = req;
    for (int i = 0; i < n; i++) begin
      int v;
      v = int'($signed(16'($urandom)));
      send(v, ($urandom % 4 == 0) ? int'($urandom % 3) : 0);
    end
    drain();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C0D));
    rst_n = 1'b0; rate_fast = 1'b1; hp_bypass = 1'b1; in_vld = 1'b0; in_dat = '0;
    // R1: idle outputs right after reset release
    do_reset(1'b1, 1'b1);
    check(out_vld == 1'b0, "R1 out_vld", int'(out_vld), 0);
    check(out_dat == '0, "R1 out_dat", int'(out_dat), 0);

    // R9: impulse latency, even phase 4 cycles after strobe, odd next cycle
    cur_req = "R9 R6 R7 impulse";
    @(negedge clk);
    in_vld = 1'b1; in_dat = 16'sd4000; model_push(4000);
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (i == 1) in_vld = 1'b0;
      check(out_vld == ((i == 4) || (i == 5)), "R9 latency", int'(out_vld), int'((i == 4) || (i == 5)));
    end
    drain();

    // R8: positive saturation
    do_reset(1'b1, 1'b1);
    cur_req = "R8 positive";
    send(-32768, 0); send(32767, 0); send(32767, 0); send(-32768, 0);
    drain();
    check(max_seen == 8191, "R8 max", max_seen, 8191);

    // R8: negative saturation
    do_reset(1'b1, 1'b1);
    cur_req = "R8 negative";
    send(32767, 0); send(-32768, 0); send(-32768, 0); send(32767, 0);
    drain();
    check(min_seen == -8192, "R8 min", min_seen, -8192);

    // R4: constant input decays toward zero with the high-pass active
    do_reset(1'b1, 1'b0);
    cur_req = "R4 dc decay";
    for (int i = 0; i < 600; i++) send(12000, 0);
    drain();
    check(last_seen <= 16 && last_seen >= -16, "R4 settled", last_seen, 0);
    check(max_seen > 2000, "R4 initial step", max_seen, 2001);

    // R3: copy insertion, single sample makes four outputs
    do_reset(1'b0, 1'b1);
    cur_req = "R3 copy";
    send(8000, 0);
    drain();

    random_run(1'b1, 1'b1, 150, "R2 R5 R6 R7 fast bypass");
    random_run(1'b1, 1'b0, 150, "R2 R4 R6 R7 fast filter");
    random_run(1'b0, 1'b1, 120, "R3 R5 slow bypass");
    random_run(1'b0, 1'b0, 120, "R3 R4 slow filter");

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule